// File: doc/BRIEF.md
# Cache Load Parity Checker

This block sits beside the data-cache read path and judges every load that hits. It receives the double word read from the cache array, the parity bits stored with it, the byte lanes the load wants, and the instruction address of the load. Every lane of the double word is checked, whatever the byte mask says. If any lane is bad while checking is on, the load is stopped from writing its result into the destination register in that same cycle.

The error is not reported straight away, because the load may be speculative. The block keeps the error and the instruction address in a single tracking slot. It raises a one-cycle machine-check pulse, with the captured address, only once the pipeline commits that load. A squash throws the slot away. A sticky status flag records that a data-cache parity report happened.

Checking is turned on through a small configuration write. That write also holds a second enable bit, which is passed on to the instruction-cache side.

Top module: `ld_par_chk`

## Requirements
- R1: Each 8-bit lane of the 64-bit double word has one even-parity bit, `ld_par[i]` for `ld_data[8*i+7:8*i]`. The bit is correct when it equals the XOR of the lane's eight data bits. A load is bad when any of the 8 lanes is incorrect.
- R2: `ld_mask` does not narrow the check. A load that selects a single lane is still bad when a parity error sits in a lane it does not select.
- R3: After reset, `dc_par_en` and `ic_par_en` are 0. A cycle with `cfg_we` high loads them from `cfg_dc_en` and `cfg_ic_en`, visible after that edge. While `dc_par_en` is 0, no load is bad: `rf_we` follows `ld_valid` and no report follows.
- R4: In the cycle a load is presented, `rf_we` is 0 if the load is bad and equals `ld_valid` otherwise. `rf_wdata` carries the lanes whose `ld_mask` bit is 1, with the other lanes zero.
- R5: A bad load is held in the slot and reports nothing until `ld_commit` is sampled high. `par_err` is then high in the cycle after that edge.
- R6: `ld_squash` empties the slot without a report, and it takes priority over `ld_commit` in the same cycle.
- R7: During the `par_err` pulse, `err_iaddr` equals the `ld_iaddr` of the failing load. It holds that value until the next report.
- R8: `dcpe_stat` is set together with each `par_err` pulse and stays set. A cycle with `stat_clr` high clears it, unless a report sets it in that same cycle.
- R9: `par_err` lasts one cycle per report. A commit while the slot holds no bad load gives no pulse.
- R10: A new load presented in the same cycle as a commit enters the slot while the older load is reported. The new load is then reported on its own later commit, with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the enable bits |
| cfg_dc_en | input | 1 | Data-cache parity enable value to write |
| cfg_ic_en | input | 1 | Instruction-cache parity enable value to write |
| stat_clr | input | 1 | Clears the sticky status flag |
| ld_valid | input | 1 | A cache-hit load is presented this cycle |
| ld_data | input | 64 | Double word read from the cache array |
| ld_par | input | 8 | Stored parity bit per lane |
| ld_mask | input | 8 | Lanes the load requests |
| ld_iaddr | input | 32 | Instruction address of the load |
| ld_commit | input | 1 | The tracked load commits |
| ld_squash | input | 1 | The tracked load is discarded |
| rf_we | output | 1 | Register-file write enable for the load result |
| rf_wdata | output | 64 | Load data, with unrequested lanes zeroed |
| par_err | output | 1 | One-cycle machine-check parity report |
| err_iaddr | output | 32 | Instruction address of the reported load |
| dcpe_stat | output | 1 | Sticky data-cache parity status |
| dc_par_en | output | 1 | Data-cache parity checking enabled |
| ic_par_en | output | 1 | Enable bit passed to the instruction-cache side |

## Verification
Two pairs of events can fall in the same cycle. A commit can meet a squash, and a commit can meet the arrival of a new bad load. The bench creates the first pair by raising `ld_commit` and `ld_squash` together on a pending bad load, and expects no pulse and an empty slot. It creates the second by presenting a second bad load during the commit of the first. It then expects two separate pulses, each carrying its own instruction address.

// File: rtl/ld_par_pkg.sv
package ld_par_pkg;
   typedef enum logic {
      PAR_EVEN_E = 1'b0,
      PAR_ODD_E  = 1'b1
   } par_kind_e;
endpackage

// File: rtl/ld_par_lane.sv
module ld_par_lane
   import ld_par_pkg::*;
#(
   parameter int        LANE_W   = 8,
   parameter par_kind_e PAR_KIND = PAR_EVEN_E
) (
   input  logic [LANE_W-1:0] lane_i,
   input  logic              pbit_i,
   output logic              bad_o
);
   generate
      if (PAR_KIND == PAR_EVEN_E) begin : g_even
         assign bad_o = ^{lane_i, pbit_i};
      end else begin : g_odd
         assign bad_o = ~^{lane_i, pbit_i};
      end
   endgenerate
endmodule

// File: rtl/ld_par_cfg.sv
module ld_par_cfg (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_we,
   input  logic cfg_dc_en,
   input  logic cfg_ic_en,
   input  logic stat_clr,
   input  logic report_i,
   output logic dc_en_o,
   output logic ic_en_o,
   output logic stat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dc_en_o <= 1'b0;
         ic_en_o <= 1'b0;
         stat_o  <= 1'b0;
      end else begin
         if (cfg_we) begin
            dc_en_o <= cfg_dc_en;
            ic_en_o <= cfg_ic_en;
         end
         if (stat_clr) stat_o <= 1'b0;
         if (report_i) stat_o <= 1'b1;
      end
   end

   // R8: each report leaves the status flag set
   assert_stat_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      report_i |=> stat_o);
   // R8: the flag only rises because of a report
   assert_stat_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o) |-> $past(report_i));
endmodule

// File: rtl/ld_par_track.sv
module ld_par_track #(
   parameter int IADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_valid_i,
   input  logic               load_bad_i,
   input  logic [IADDR_W-1:0] ld_iaddr_i,
   input  logic               commit_i,
   input  logic               squash_i,
   output logic               err_o,
   output logic [IADDR_W-1:0] err_iaddr_o
);
   logic               pend_q;
   logic [IADDR_W-1:0] pend_iaddr_q;
   logic               fire;

   assign fire = commit_i & ~squash_i & pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q       <= 1'b0;
         pend_iaddr_q <= '0;
         err_o        <= 1'b0;
         err_iaddr_o  <= '0;
      end else begin
         err_o <= fire;
         if (fire) err_iaddr_o <= pend_iaddr_q;
         if (ld_valid_i) begin
            pend_q       <= load_bad_i;
            pend_iaddr_q <= ld_iaddr_i;
         end else if (commit_i | squash_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   // R6: a squash never leads to a report in the next cycle
   assert_squash_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i |=> !err_o);
   // R5: a report always follows a sampled commit
   assert_report_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(commit_i));
   // R7: the reported address moves only when a report starts
   assert_iaddr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !err_o |-> $stable(err_iaddr_o));
endmodule

// File: rtl/ld_par_chk.sv
module ld_par_chk
   import ld_par_pkg::*;
#(
   parameter int        DATA_W   = 64,
   parameter int        LANE_W   = 8,
   parameter int        IADDR_W  = 32,
   parameter par_kind_e PAR_KIND = PAR_EVEN_E
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       cfg_dc_en,
   input  logic                       cfg_ic_en,
   input  logic                       stat_clr,
   input  logic                       ld_valid,
   input  logic [DATA_W-1:0]          ld_data,
   input  logic [DATA_W/LANE_W-1:0]   ld_par,
   input  logic [DATA_W/LANE_W-1:0]   ld_mask,
   input  logic [IADDR_W-1:0]         ld_iaddr,
   input  logic                       ld_commit,
   input  logic                       ld_squash,
   output logic                       rf_we,
   output logic [DATA_W-1:0]          rf_wdata,
   output logic                       par_err,
   output logic [IADDR_W-1:0]         err_iaddr,
   output logic                       dcpe_stat,
   output logic                       dc_par_en,
   output logic                       ic_par_en
);
   localparam int LANES = DATA_W / LANE_W;

   generate
      if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_width
         $error("ld_par_chk: DATA_W must be a whole multiple of LANE_W");
      end
      if (IADDR_W < 1) begin : g_bad_iaddr
         $error("ld_par_chk: IADDR_W must be positive");
      end
   endgenerate

   logic [LANES-1:0] lane_bad;
   logic             load_bad;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      ld_par_lane #(.LANE_W(LANE_W), .PAR_KIND(PAR_KIND)) u_lane (
         .lane_i (ld_data[i*LANE_W +: LANE_W]),
         .pbit_i (ld_par[i]),
         .bad_o  (lane_bad[i])
      );
      assign rf_wdata[i*LANE_W +: LANE_W] =
         ld_mask[i] ? ld_data[i*LANE_W +: LANE_W] : '0;
   end

   assign load_bad = ld_valid & dc_par_en & (|lane_bad);
   assign rf_we    = ld_valid & ~load_bad;

   ld_par_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_dc_en (cfg_dc_en),
      .cfg_ic_en (cfg_ic_en),
      .stat_clr  (stat_clr),
      .report_i  (par_err),
      .dc_en_o   (dc_par_en),
      .ic_en_o   (ic_par_en),
      .stat_o    (dcpe_stat)
   );

   ld_par_track #(.IADDR_W(IADDR_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_valid_i  (ld_valid),
      .load_bad_i  (load_bad),
      .ld_iaddr_i  (ld_iaddr),
      .commit_i    (ld_commit),
      .squash_i    (ld_squash),
      .err_o       (par_err),
      .err_iaddr_o (err_iaddr)
   );

   // R4: no write-back while checking is on and any lane is bad
   assert_no_bad_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_par_en && (|lane_bad)) |-> !rf_we);
   // R3: with checking off, every presented load writes back
   assert_off_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dc_par_en && ld_valid) |-> rf_we);
endmodule

// File: tb/ld_par_chk_tb.sv
`timescale 1ns/1ps
module ld_par_chk_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_dc_en, cfg_ic_en, stat_clr;
   logic        ld_valid, ld_commit, ld_squash;
   logic [63:0] ld_data;
   logic [7:0]  ld_par, ld_mask;
   logic [31:0] ld_iaddr;
   logic        rf_we, par_err, dcpe_stat, dc_par_en, ic_par_en;
   logic [63:0] rf_wdata;
   logic [31:0] err_iaddr;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   ld_par_chk u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dc_en(cfg_dc_en),
      .cfg_ic_en(cfg_ic_en), .stat_clr(stat_clr), .ld_valid(ld_valid),
      .ld_data(ld_data), .ld_par(ld_par), .ld_mask(ld_mask),
      .ld_iaddr(ld_iaddr), .ld_commit(ld_commit), .ld_squash(ld_squash),
      .rf_we(rf_we), .rf_wdata(rf_wdata), .par_err(par_err),
      .err_iaddr(err_iaddr), .dcpe_stat(dcpe_stat), .dc_par_en(dc_par_en),
      .ic_par_en(ic_par_en)
   );

   localparam logic [63:0] TV_D [0:7] = '{
      64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0BAD_F00D,
      64'h8000_0000_0000_0001, 64'h5A5A_A5A5_3C3C_C3C3,
      64'h0F0F_F0F0_1234_8765, 64'h7777_1111_2222_EEEE};
   localparam logic [7:0] TV_F [0:7] = '{
      8'h00, 8'h01, 8'h80, 8'h00, 8'h24, 8'hFF, 8'h10, 8'h00};
   localparam logic [7:0] TV_M [0:7] = '{
      8'hFF, 8'h01, 8'h01, 8'h0F, 8'h02, 8'hF0, 8'h80, 8'h3C};

   function automatic logic [7:0] gen_par(input logic [63:0] d);
      logic [7:0] p;
      for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
      return p;
   endfunction

   function automatic logic [63:0] mask_data(input logic [63:0] d, input logic [7:0] m);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = m[i] ? d[i*8 +: 8] : 8'h00;
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic present(input logic [63:0] d, input logic [7:0] f,
                          input logic [7:0] m, input logic [31:0] ia);
      ld_valid = 1'b1; ld_data = d; ld_par = gen_par(d) ^ f;
      ld_mask = m; ld_iaddr = ia;
   endtask

   // one full load: present, check write-back, commit, check report
   task automatic run_load(input string req, input logic [63:0] d, input logic [7:0] f,
                           input logic [7:0] m, input logic [31:0] ia, input logic en);
      logic bad;
      bad = en && (f != 8'h00);
      present(d, f, m, ia);
      #1;
      chk({req, " R4 rf_we"}, rf_we, !bad);
      if (!bad) chk({req, " R4 rf_wdata"}, rf_wdata, mask_data(d, m));
      tick();
      ld_valid = 1'b0; ld_commit = 1'b1;
      #1;
      chk({req, " R5 no pulse before commit"}, par_err, 0);
      tick();
      ld_commit = 1'b0;
      chk({req, " R5 pulse after commit"}, par_err, bad);
      if (bad) chk({req, " R7 err_iaddr"}, err_iaddr, ia);
      tick();
      chk({req, " R9 pulse one cycle"}, par_err, 0);
   endtask

   initial begin
      #(8 * 200000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 0; cfg_dc_en = 0; cfg_ic_en = 0; stat_clr = 0;
      ld_valid = 0; ld_commit = 0; ld_squash = 0;
      ld_data = '0; ld_par = '0; ld_mask = '0; ld_iaddr = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R3 dc_par_en reset", dc_par_en, 0);
      chk("R3 ic_par_en reset", ic_par_en, 0);
      chk("R8 dcpe_stat reset", dcpe_stat, 0);
      chk("R9 par_err reset", par_err, 0);
      tick();

      // R3: checking off, bad load passes
      run_load("R3 disabled", 64'h1111_2222_3333_4444, 8'h08, 8'hFF, 32'h100, 1'b0);
      chk("R3 no status when off", dcpe_stat, 0);

      cfg_we = 1; cfg_dc_en = 1; cfg_ic_en = 0;
      tick();
      cfg_we = 0;
      chk("R3 dc_par_en set", dc_par_en, 1);
      chk("R3 ic_par_en clear", ic_par_en, 0);

      // R1 / R2 vector table
      for (int i = 0; i < 8; i++) begin
         run_load("R1 R2 table", TV_D[i], TV_F[i], TV_M[i], 32'h2000 + i * 4, 1'b1);
      end

      // R7 hold and R8 sticky
      tick();
      chk("R7 err_iaddr held", err_iaddr, 32'h2000 + 6 * 4);
      chk("R8 status sticky", dcpe_stat, 1);
      stat_clr = 1; tick(); stat_clr = 0;
      chk("R8 status cleared", dcpe_stat, 0);

      // R6: commit and squash in the same cycle
      present(64'hCAFE_0000_0000_0000, 8'h40, 8'h01, 32'h3000);
      tick();
      ld_valid = 0; ld_commit = 1; ld_squash = 1;
      tick();
      ld_commit = 0; ld_squash = 0;
      chk("R6 squash beats commit", par_err, 0);
      ld_commit = 1; tick(); ld_commit = 0;
      chk("R6 slot emptied", par_err, 0);

      // R6: squash alone, then commit later
      present(64'h0000_BEEF_0000_0000, 8'h02, 8'hFF, 32'h3100);
      tick();
      ld_valid = 0; ld_squash = 1; tick(); ld_squash = 0;
      ld_commit = 1; tick(); ld_commit = 0;
      chk("R6 squash then commit", par_err, 0);

      // R9: commit with nothing pending
      ld_commit = 1; tick(); ld_commit = 0;
      chk("R9 idle commit", par_err, 0);
      chk("R8 no status without report", dcpe_stat, 0);

      // R10: new bad load arrives with the commit of the old one
      present(64'h1234_5678_0000_0001, 8'h01, 8'h01, 32'h4000);
      tick();
      present(64'h0000_0001_1234_5678, 8'h80, 8'h80, 32'h4004);
      ld_commit = 1;
      #1;
      chk("R10 second load blocked", rf_we, 0);
      tick();
      ld_valid = 0;
      chk("R10 first report", par_err, 1);
      chk("R10 first address", err_iaddr, 32'h4000);
      tick();
      ld_commit = 0;
      chk("R10 second report", par_err, 1);
      chk("R10 second address", err_iaddr, 32'h4004);
      chk("R8 status set", dcpe_stat, 1);
      tick();
      chk("R9 back to idle", par_err, 0);

      // R8: clear and report in the same cycle, set wins
      present(64'h0, 8'h01, 8'hFF, 32'h5000);
      tick();
      ld_valid = 0; ld_commit = 1; tick();
      ld_commit = 0; stat_clr = 1;
      chk("R5 pulse", par_err, 1);
      tick(); stat_clr = 0;
      chk("R8 set beats clear", dcpe_stat, 1);

      // R3: instruction side enable and turning checking off again
      cfg_we = 1; cfg_dc_en = 0; cfg_ic_en = 1; tick(); cfg_we = 0;
      chk("R3 ic_par_en set", ic_par_en, 1);
      chk("R3 dc_par_en off", dc_par_en, 0);
      run_load("R3 off again", 64'hFFFF_0000_FFFF_0000, 8'hFF, 8'h0F, 32'h6000, 1'b0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule